// File: doc/BRIEF.md
# Streaming Two-Input Merge Cell

This block joins two key streams, each already in ascending order, into a single ascending stream. Each input has a valid/ready handshake and an end-of-batch flag. Every accepted key lands in a small shift-register FIFO on its own side. New data always enters at position 0, and the oldest entry is read at the address one below the fill count. One unsigned magnitude comparator looks at the keys that will be at the two FIFO heads on the next cycle. Its one-bit verdict is stored in a register. In the next cycle that stored bit steers the output multiplexer, pops the chosen FIFO and loads a registered output stage. This path keeps a rate of one key per clock without a multi-stage compare pipeline.

When two keys are equal, the A side is taken first, so the merge is stable. After one side has delivered its final key, the cell stops comparing and drains the other side. The output end flag is raised on the very last key of the pair of batches. After that key is loaded, the cell starts on the next pair of batches. A stalled output freezes the output register, the compare bit and both FIFOs.

Top module: `merge_cell`

## Requirements
- R1: Within one batch pair, the output carries every accepted key of both inputs exactly once, in ascending unsigned order. Equal keys are all emitted.
- R2: When both inputs offer a key every cycle and m_ready stays high, the output accepts a key on every consecutive cycle from the first merged key to the last.
- R3: Suppose a key is accepted on both inputs at the same edge with both end flags set. The smaller key is valid on the output after the next edge, and the larger one follows one edge later.
- R4: A key from one side is never emitted while the other side's FIFO is empty and that side has not yet delivered its final key.
- R5: Each input's ready is low exactly when its FIFO holds DEPTH keys (default 16), and high otherwise.
- R6: After one side's final key has been popped, the remaining keys of the other side are emitted in their arrival order without waiting.
- R7: m_last is high on the final key of a batch pair and on no other key. No output appears after it until new input arrives.
- R8: While m_valid is high and m_ready is low, m_key and m_last hold their values and no key is lost.
- R9: The comparison covers all KEY_W bits as unsigned magnitudes. Keys that differ only above bit 31 are ordered correctly when KEY_W is 64.
- R10: A new batch pair supplied right after a completed one is merged correctly with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Side A key offered |
| a_ready | output | 1 | Side A FIFO not full |
| a_key | input | KEY_W | Side A key |
| a_last | input | 1 | Side A final key of its batch |
| b_valid | input | 1 | Side B key offered |
| b_ready | output | 1 | Side B FIFO not full |
| b_key | input | KEY_W | Side B key |
| b_last | input | 1 | Side B final key of its batch |
| m_valid | output | 1 | Merged key valid |
| m_ready | input | 1 | Downstream accepts merged key |
| m_key | output | KEY_W | Merged key |
| m_last | output | 1 | Final merged key of the batch pair |

## Verification
Input handshakes are counted at the edge that follows the cycle in which valid and ready are both high. The first merged key is due on m_valid one edge after that. Each following key in steady state is due one edge after the previous output handshake. Ready changes one edge after the push that fills a FIFO or the pop that frees a slot. The bench drives inputs on the falling edge. It samples ready and the output shortly after that, so each sample shows the state the next rising edge will act on. Every expected key and flag is counted against that edge, and the bench compares each output handshake with a merge of the two stimulus lists that it computes itself. The latency case checks m_valid at the exact falling edges after acceptance, expecting low, then the smaller key, then the larger key with m_last.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic {
    PICK_B = 1'b0,
    PICK_A = 1'b1
  } pick_e;
endpackage

// File: rtl/mc_srl_fifo.sv
module mc_srl_fifo #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [KEY_W-1:0] din_key,
  input  logic             din_last,
  input  logic             pop,
  output logic             not_full,
  output logic             not_empty,
  output logic [KEY_W-1:0] head_key,
  output logic             head_last,
  output logic [KEY_W-1:0] nxt_key
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = KEY_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] hidx;
  logic [EW-1:0] nxt_ent;

  // shift register storage: entry 0 always receives the newest word
  always_ff @(posedge clk) begin
    if (push) begin
      mem[0] <= {din_last, din_key};
      for (int i = 1; i < DEPTH; i++) mem[i] <= mem[i-1];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + CW'(1);
    else if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (push || pop)  cnt_q <= cnt_d;
  end

  assign not_full  = (cnt_q != CW'(DEPTH));
  assign not_empty = (cnt_q != '0);
  assign hidx      = not_empty ? AW'(cnt_q - CW'(1)) : '0;
  assign {head_last, head_key} = mem[hidx];

  // entry that will sit at the head after this cycle's push and pop
  always_comb begin
    nxt_ent = '0;
    if (cnt_d != '0) begin
      if (push) begin
        if (cnt_d == CW'(1)) nxt_ent = {din_last, din_key};
        else                 nxt_ent = mem[AW'(cnt_d - CW'(2))];
      end else begin
        nxt_ent = mem[AW'(cnt_d - CW'(1))];
      end
    end
  end
  assign nxt_key = nxt_ent[KEY_W-1:0];
endmodule

// File: rtl/mc_pick.sv
module mc_pick
  import mc_pkg::*;
#(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [KEY_W-1:0] key_a,
  input  logic [KEY_W-1:0] key_b,
  output pick_e            pick_q
);
  pick_e pick_d;

  // single comparator; ties go to side A
  assign pick_d = (key_a <= key_b) ? PICK_A : PICK_B;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pick_q <= PICK_B;
    else if (upd) pick_q <= pick_d;
  end
endmodule

// File: rtl/mc_out_reg.sv
module mc_out_reg #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [KEY_W-1:0] key_in,
  input  logic             last_in,
  output logic             vld_q,
  output logic [KEY_W-1:0] key_q,
  output logic             last_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld_q <= 1'b0;
    else if (adv) vld_q <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= '0;
      last_q <= 1'b0;
    end else if (adv && load) begin
      key_q  <= key_in;
      last_q <= last_in;
    end
  end
endmodule

// File: rtl/merge_cell.sv
module merge_cell
  import mc_pkg::*;
#(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [KEY_W-1:0] a_key,
  input  logic             a_last,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [KEY_W-1:0] b_key,
  input  logic             b_last,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [KEY_W-1:0] m_key,
  output logic             m_last
);
  localparam int NSIDE = 2;
  localparam int SA = 0;
  localparam int SB = 1;

  logic [NSIDE-1:0] in_vld, in_lst, push, pop, rdy, ne;
  logic [KEY_W-1:0] in_key [NSIDE];
  logic [KEY_W-1:0] hd_key [NSIDE];
  logic [KEY_W-1:0] nx_key [NSIDE];
  logic [NSIDE-1:0] hd_lst;

  assign in_vld = {b_valid, a_valid};
  assign in_lst = {b_last, a_last};
  assign in_key[SA] = a_key;
  assign in_key[SB] = b_key;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    assign push[s] = in_vld[s] && rdy[s];
    mc_srl_fifo #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push[s]),
      .din_key   (in_key[s]),
      .din_last  (in_lst[s]),
      .pop       (pop[s]),
      .not_full  (rdy[s]),
      .not_empty (ne[s]),
      .head_key  (hd_key[s]),
      .head_last (hd_lst[s]),
      .nxt_key   (nx_key[s])
    );
  end

  assign a_ready = rdy[SA];
  assign b_ready = rdy[SB];

  pick_e pick_q;
  logic  adv, avail_a, avail_b, take_a, take_b, fin;
  logic  done_a_q, done_b_q, done_a_d, done_b_d;
  logic  [KEY_W-1:0] sel_key;

  mc_pick #(.KEY_W(KEY_W)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (|push || |pop),
    .key_a  (nx_key[SA]),
    .key_b  (nx_key[SB]),
    .pick_q (pick_q)
  );

  // selection, pop and end-of-batch bookkeeping
  always_comb begin
    adv     = !m_valid || m_ready;
    avail_a = ne[SA] && !done_a_q;
    avail_b = ne[SB] && !done_b_q;
    take_a  = adv && avail_a && (avail_b ? (pick_q == PICK_A) : done_b_q);
    take_b  = adv && avail_b && (avail_a ? (pick_q == PICK_B) : done_a_q);
    fin     = (take_a && hd_lst[SA] && done_b_q) ||
              (take_b && hd_lst[SB] && done_a_q);
    done_a_d = done_a_q;
    done_b_d = done_b_q;
    if (fin) begin
      done_a_d = 1'b0;
      done_b_d = 1'b0;
    end else begin
      if (take_a && hd_lst[SA]) done_a_d = 1'b1;
      if (take_b && hd_lst[SB]) done_b_d = 1'b1;
    end
    sel_key = take_a ? hd_key[SA] : hd_key[SB];
  end

  assign pop = {take_b, take_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_a_q <= 1'b0;
      done_b_q <= 1'b0;
    end else if (take_a || take_b) begin
      done_a_q <= done_a_d;
      done_b_q <= done_b_d;
    end
  end

  mc_out_reg #(.KEY_W(KEY_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .load    (take_a || take_b),
    .key_in  (sel_key),
    .last_in (fin),
    .vld_q   (m_valid),
    .key_q   (m_key),
    .last_q  (m_last)
  );
endmodule

// File: rtl/merge_cell_chk.sv
module merge_cell_chk #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_valid,
  input logic             a_ready,
  input logic             b_valid,
  input logic             b_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [KEY_W-1:0] m_key,
  input logic             m_last
);
  logic [15:0]      occ_q;
  logic [KEY_W-1:0] prev_q;
  logic             inb_q;
  logic             acc;
  logic [1:0]       nin;

  assign acc = m_valid && m_ready;
  assign nin = {1'b0, a_valid && a_ready} + {1'b0, b_valid && b_ready};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      prev_q <= '0;
      inb_q  <= 1'b0;
    end else begin
      occ_q <= occ_q + 16'(nin) - 16'(acc);
      if (acc) begin
        prev_q <= m_key;
        inb_q  <= !m_last;
      end
    end
  end

  // R1: ascending order inside a batch pair
  a_r1_order: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && inb_q) |-> (m_key >= prev_q));

  // R1: no key leaves that was never accepted (no duplicates)
  a_r1_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (occ_q != '0));

  // R5: the cell never holds more than both FIFOs plus the output stage
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= 16'(2 * DEPTH + 1));

  // R8: stalled output holds its key and flag
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_key) && $stable(m_last)));
endmodule

bind merge_cell merge_cell_chk #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_valid (a_valid),
  .a_ready (a_ready),
  .b_valid (b_valid),
  .b_ready (b_ready),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_key   (m_key),
  .m_last  (m_last)
);

// File: tb/sim_merge_cell.sv
module sim_merge_cell;
  localparam int KW = 64;
  localparam int DP = 16;

  logic clk, rst_n;
  logic a_valid, a_ready, a_last, b_valid, b_ready, b_last;
  logic m_valid, m_ready, m_last;
  logic [KW-1:0] a_key, b_key, m_key;

  int n_chk = 0;
  int n_bad = 0;
  logic [KW-1:0] sa [64];
  logic [KW-1:0] sb [64];
  int na, nb;
  int first_cyc, last_cyc;

  merge_cell #(.KEY_W(KW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_key(a_key), .a_last(a_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_key(b_key), .b_last(b_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_key(m_key), .m_last(m_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    n_bad++;
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [KW-1:0] act,
                     input logic [KW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    a_valid = 0; a_key = '0; a_last = 0;
    b_valid = 0; b_key = '0; b_last = 0;
  endtask

  // drives both lists (side A starting at pre_a) and checks every output
  task automatic run_case(input string req, input int pre_a, input bit stall);
    logic [KW-1:0] exp [128];
    int ia = pre_a, ib = 0, no = 0, cyc = 0, i = 0, j = 0;
    bit fin = 0, hv = 0;
    logic [KW-1:0] hk = '0;
    logic hl = 0;
    while (i < na || j < nb) begin
      if (j >= nb || (i < na && sa[i] <= sb[j])) begin exp[i+j] = sa[i]; i++; end
      else begin exp[i+j] = sb[j]; j++; end
    end
    first_cyc = -1; last_cyc = -1;
    while (!fin && cyc < 4000) begin
      @(negedge clk); cyc++;
      a_valid = (ia < na); a_key = (ia < na) ? sa[ia] : '0; a_last = (ia == na - 1);
      b_valid = (ib < nb); b_key = (ib < nb) ? sb[ib] : '0; b_last = (ib == nb - 1);
      m_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (hv) chk(m_valid && m_key == hk && m_last == hl, "R8 held output", m_key, hk);
      hv = m_valid && !m_ready; hk = m_key; hl = m_last;
      if (a_valid && a_ready) ia++;
      if (b_valid && b_ready) ib++;
      if (m_valid && m_ready) begin
        if (first_cyc < 0) first_cyc = cyc;
        last_cyc = cyc;
        chk(m_key == exp[no], req, m_key, exp[no]);
        chk(m_last == (no == na + nb - 1), "R7 last flag", 64'(m_last),
            64'(no == na + nb - 1));
        if (m_last) fin = 1;
        no++;
      end
    end
    chk(no == na + nb, "R1 output count", 64'(no), 64'(na + nb));
    @(negedge clk); idle_inputs(); m_ready = 1;
    repeat (2) begin
      @(negedge clk); #1;
      chk(!m_valid, "R7 nothing after final key", 64'(m_valid), 64'd0);
    end
  endtask

  task automatic t_reset();
    idle_inputs(); m_ready = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid, "R7 reset valid", 64'(m_valid), 64'd0);
    chk(a_ready && b_ready, "R5 reset ready", 64'({a_ready, b_ready}), 64'd3);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_latency();
    @(negedge clk);
    a_valid = 1; a_key = 64'd3; a_last = 1;
    b_valid = 1; b_key = 64'd7; b_last = 1;
    m_ready = 1;
    @(negedge clk); idle_inputs(); #1;
    chk(!m_valid, "R3 not yet valid", 64'(m_valid), 64'd0);
    @(negedge clk); #1;
    chk(m_valid && m_key == 64'd3 && !m_last, "R3 smaller key", m_key, 64'd3);
    @(negedge clk); #1;
    chk(m_valid && m_key == 64'd7 && m_last, "R3 larger key last", m_key, 64'd7);
    @(negedge clk); #1;
    chk(!m_valid, "R7 idle after pair", 64'(m_valid), 64'd0);
  endtask

  task automatic t_basic();
    na = 5; nb = 4;
    for (int k = 0; k < 5; k++) sa[k] = 64'(10 * k + 1);
    for (int k = 0; k < 4; k++) sb[k] = 64'(10 * k + 5);
    run_case("R1 interleaved", 0, 0);
  endtask

  task automatic t_next_batch();
    na = 3; nb = 3;
    sa[0] = 2; sa[1] = 4; sa[2] = 100;
    sb[0] = 1; sb[1] = 50; sb[2] = 60;
    run_case("R10 second batch", 0, 0);
  endtask

  task automatic t_throughput();
    na = 20; nb = 20;
    for (int k = 0; k < 20; k++) begin sa[k] = 64'(3 * k); sb[k] = 64'(3 * k + 1); end
    run_case("R1 rate run", 0, 0);
    chk(last_cyc - first_cyc == 39, "R2 one key per cycle",
        64'(last_cyc - first_cyc), 64'd39);
  endtask

  task automatic t_ties();
    na = 4; nb = 4;
    for (int k = 0; k < 4; k++) begin sa[k] = 64'(k / 2); sb[k] = 64'(k / 2); end
    run_case("R1 equal keys", 0, 0);
  endtask

  task automatic t_stall();
    na = 7; nb = 6;
    for (int k = 0; k < 7; k++) sa[k] = 64'(k * k);
    for (int k = 0; k < 6; k++) sb[k] = 64'(2 * k + 1);
    run_case("R8 stalled merge", 0, 1);
  endtask

  task automatic t_drain();
    na = 1; nb = 6;
    sa[0] = 1;
    for (int k = 0; k < 6; k++) sb[k] = 64'(k + 2);
    run_case("R6 drain B", 0, 0);
    na = 4; nb = 1;
    for (int k = 0; k < 4; k++) sa[k] = 64'(k + 5);
    sb[0] = 0;
    run_case("R6 drain A", 0, 0);
  endtask

  task automatic t_fill();
    na = DP; nb = 1;
    for (int k = 0; k < DP; k++) sa[k] = 64'(k + 1);
    sb[0] = 64'd1000;
    m_ready = 1;
    for (int k = 0; k < DP; k++) begin
      @(negedge clk);
      a_valid = 1; a_key = sa[k]; a_last = (k == DP - 1);
      #1;
      chk(a_ready, "R5 ready while not full", 64'(a_ready), 64'd1);
      chk(!m_valid, "R4 waits for B", 64'(m_valid), 64'd0);
    end
    @(negedge clk); idle_inputs(); #1;
    chk(!a_ready, "R5 ready low when full", 64'(a_ready), 64'd0);
    repeat (3) begin
      @(negedge clk); #1;
      chk(!m_valid, "R4 still waiting", 64'(m_valid), 64'd0);
    end
    run_case("R4 release after B", DP, 0);
  endtask

  task automatic t_wide();
    na = 2; nb = 2;
    sa[0] = 64'd5;            sa[1] = 64'h8000_0000_0000_0000;
    sb[0] = 64'h1_0000_0001;  sb[1] = 64'h8000_0000_0000_0001;
    run_case("R9 wide keys", 0, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_basic();
    t_next_batch();
    t_throughput();
    t_ties();
    t_stall();
    t_drain();
    t_fill();
    t_wide();
    summary();
    $finish;
  end
endmodule